// File: doc/BRIEF.md
# Clock-Replacement Address Translation Cache

This block is a small fully associative cache of page-to-frame translations sitting in front of a page-table walker. A virtual address is split into a page number and an offset; the page number is compared against every valid entry at once. A hit returns the cached frame number joined with the untouched offset in the same cycle the request is accepted. A miss holds the block busy, sends the page number to an external walker and waits for its answer. A present answer produces the real address and installs the mapping. An absent answer signals a page fault and installs nothing.

Refill victims are picked by the second-chance clock policy. Each entry has a reference bit. The bit is set when the entry is loaded and again each time it hits. Empty slots are filled first. When no slot is empty, a rotating hand walks the slots. It clears set reference bits as it passes and stops at the first clear one. An `active_ways` input limits how many of the slots take part, so that small configurations can be exercised.

Top module: `tlb_clock`

## Requirements
- R1: When `req_valid` is high and `req_ready` is high and a usable valid entry holds the request's page number (upper 20 bits of `req_vaddr`), `resp_valid` is high in that same cycle with `resp_fault` low and `resp_paddr` equal to {stored frame, lower 12 offset bits of `req_vaddr`}.
- R2: A request accepted without a hit gives no response in its cycle. From the next cycle `walk_req_valid` is high with `walk_req_page` equal to the missed page and `req_ready` low, until the walker answers.
- R3: In the cycle `walk_rsp_valid` is high while a walk is pending and `walk_rsp_present` is high, `resp_valid` is high with `resp_fault` low and `resp_paddr` = {`walk_rsp_frame`, pending offset}. The mapping is installed, so a later lookup of that page hits.
- R4: If `walk_rsp_present` is low on the walker answer, `resp_valid` and `resp_fault` are high, `resp_paddr` is zero, and no entry changes; a later lookup of that page misses again.
- R5: An entry's reference bit is set when it is installed and when it hits.
- R6: While any usable entry is invalid, a refill goes into the lowest-numbered invalid usable entry and the hand does not move.
- R7: With all usable entries valid, the hand starts at its slot and walks upward, wrapping within the usable entries. Each entry passed with its reference bit set has that bit cleared. The first entry with a clear bit is replaced, and the hand moves to the slot after it. If every bit was set, the entry at the hand is replaced after a full circle.
- R8: Only entries with index below `active_ways` take part in lookup and refill. A value of 0 acts as 1, and a value above 8 acts as 8. A hand at or beyond the usable count acts as 0.
- R9: After reset all entries are invalid, the hand is at 0, `req_ready` is high and `walk_req_valid` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_ways | input | 4 | Number of usable entries |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address: page [31:12], offset [11:0] |
| req_ready | output | 1 | Block can accept a lookup |
| resp_valid | output | 1 | Translation result present |
| resp_paddr | output | 32 | Real address: frame [31:12], offset [11:0] |
| resp_fault | output | 1 | Result is a page fault |
| walk_req_valid | output | 1 | Walker request pending |
| walk_req_page | output | 20 | Page number to walk |
| walk_rsp_valid | input | 1 | Walker answer |
| walk_rsp_present | input | 1 | Walker found a mapping |
| walk_rsp_frame | input | 20 | Frame number from walker |

## Verification
A hit answers combinationally in the cycle of the request. The walker request appears one clock edge after a missed request is taken. The refill result is combinational on the walker answer. The bench drives each stimulus on a falling edge and samples 2 ns later, before the next rising edge. It therefore reads hits and refill results in the driven cycle and reads the walker request after the rising edge that took the miss. Hit or miss for every reference is predicted by a behavioural clock model in the bench, run over the 12-reference stream with three ways, a long eight-way sweep, shrinking of the usable count and fault pages.

// File: rtl/tlb_clock_pkg.sv
package tlb_clock_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 8,
    parameter int PAGE_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             valid_i,
    input  logic [N-1:0]             usable_i,
    input  logic [N-1:0][PAGE_W-1:0] page_i,
    input  logic [PAGE_W-1:0]        key_i,
    output logic [N-1:0]             hit_vec_o,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         hit_idx_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] & usable_i[g] & (page_i[g] == key_i);
    end

    always_comb begin
        hit_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |hit_vec_o;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     valid_i,
    input  logic [N-1:0]     ref_i,
    input  logic [N-1:0]     usable_i,
    input  logic [CNT_W-1:0] act_i,
    input  logic [IDX_W-1:0] hand_i,
    output logic [IDX_W-1:0] victim_o,
    output logic [N-1:0]     clear_o,
    output logic [IDX_W-1:0] hand_o,
    output logic             free_o
);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i,
                                              input logic [CNT_W-1:0] lim);
        if (CNT_W'(i) + CNT_W'(1) >= lim) return '0;
        return i + IDX_W'(1);
    endfunction

    logic [N-1:0]     empty_vec;
    logic [IDX_W-1:0] free_idx;

    for (genvar g = 0; g < N; g++) begin : g_empty
        assign empty_vec[g] = usable_i[g] & ~valid_i[g];
    end

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (empty_vec[i]) free_idx = IDX_W'(i);
        end
    end

    logic [IDX_W-1:0] sweep_idx;
    logic [IDX_W-1:0] sweep_vic;
    logic [N-1:0]     sweep_clr;
    logic             found;

    always_comb begin
        sweep_idx = hand_i;
        sweep_vic = hand_i;
        sweep_clr = '0;
        found     = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!found && (CNT_W'(k) < act_i)) begin
                if (!ref_i[sweep_idx]) begin
                    found     = 1'b1;
                    sweep_vic = sweep_idx;
                end else begin
                    sweep_clr[sweep_idx] = 1'b1;
                    sweep_idx            = step(sweep_idx, act_i);
                end
            end
        end
    end

    always_comb begin
        free_o = |empty_vec;
        if (free_o) begin
            victim_o = free_idx;
            clear_o  = '0;
            hand_o   = hand_i;
        end else begin
            victim_o = sweep_vic;
            clear_o  = sweep_clr;
            hand_o   = step(sweep_vic, act_i);
        end
    end

endmodule

// File: rtl/tlb_clock.sv
module tlb_clock
    import tlb_clock_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PAGE_W  = 20,
    parameter int FRAME_W = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int VA_W   = PAGE_W + OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   active_ways,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic [PA_W-1:0]    resp_paddr,
    output logic               resp_fault,
    output logic               walk_req_valid,
    output logic [PAGE_W-1:0]  walk_req_page,
    input  logic               walk_rsp_valid,
    input  logic               walk_rsp_present,
    input  logic [FRAME_W-1:0] walk_rsp_frame
);

    typedef struct packed {
        tlb_state_e                       st;
        logic [ENTRIES-1:0]               valid;
        logic [ENTRIES-1:0]               refb;
        logic [ENTRIES-1:0][PAGE_W-1:0]   page;
        logic [ENTRIES-1:0][FRAME_W-1:0]  frame;
        logic [IDX_W-1:0]                 hand;
        logic [PAGE_W-1:0]                pend_page;
        logic [OFF_W-1:0]                 pend_off;
    } regs_t;

    regs_t r_q, r_d;

    // usable-entry count after clamping
    logic [CNT_W-1:0] act_eff;
    always_comb begin
        if (active_ways == '0)                    act_eff = CNT_W'(1);
        else if (active_ways > CNT_W'(ENTRIES))   act_eff = CNT_W'(ENTRIES);
        else                                      act_eff = active_ways;
    end

    logic [ENTRIES-1:0] usable;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_usable
        assign usable[g] = (CNT_W'(g) < act_eff);
    end

    logic [IDX_W-1:0] hand_eff;
    assign hand_eff = (CNT_W'(r_q.hand) >= act_eff) ? '0 : r_q.hand;

    logic [PAGE_W-1:0] key_page;
    logic [OFF_W-1:0]  key_off;
    assign key_page = req_vaddr[VA_W-1:OFF_W];
    assign key_off  = req_vaddr[OFF_W-1:0];

    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;

    tlb_match #(.N(ENTRIES), .PAGE_W(PAGE_W)) u_match (
        .valid_i   (r_q.valid),
        .usable_i  (usable),
        .page_i    (r_q.page),
        .key_i     (key_page),
        .hit_vec_o (hit_vec),
        .hit_o     (hit_any),
        .hit_idx_o (hit_idx)
    );

    logic [IDX_W-1:0]   vic;
    logic [ENTRIES-1:0] clr;
    logic [IDX_W-1:0]   hand_nx;
    logic               has_free;

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid_i  (r_q.valid),
        .ref_i    (r_q.refb),
        .usable_i (usable),
        .act_i    (act_eff),
        .hand_i   (hand_eff),
        .victim_o (vic),
        .clear_o  (clr),
        .hand_o   (hand_nx),
        .free_o   (has_free)
    );

    logic take_req;
    logic install;
    assign take_req = req_valid && (r_q.st == ST_IDLE);
    assign install  = (r_q.st == ST_WAIT) && walk_rsp_valid && walk_rsp_present;

    always_comb begin
        r_d            = r_q;
        req_ready      = 1'b0;
        resp_valid     = 1'b0;
        resp_fault     = 1'b0;
        resp_paddr     = '0;
        walk_req_valid = 1'b0;
        walk_req_page  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (hit_any) begin
                        resp_valid         = 1'b1;
                        resp_paddr         = {r_q.frame[hit_idx], key_off};
                        r_d.refb[hit_idx]  = 1'b1;
                    end else begin
                        r_d.st        = ST_WAIT;
                        r_d.pend_page = key_page;
                        r_d.pend_off  = key_off;
                    end
                end
            end
            ST_WAIT: begin
                walk_req_valid = 1'b1;
                walk_req_page  = r_q.pend_page;
                if (walk_rsp_valid) begin
                    resp_valid = 1'b1;
                    r_d.st     = ST_IDLE;
                    if (walk_rsp_present) begin
                        resp_paddr      = {walk_rsp_frame, r_q.pend_off};
                        r_d.refb        = r_q.refb & ~clr;
                        r_d.refb[vic]   = 1'b1;
                        r_d.valid[vic]  = 1'b1;
                        r_d.page[vic]   = r_q.pend_page;
                        r_d.frame[vic]  = walk_rsp_frame;
                        r_d.hand        = hand_nx;
                    end else begin
                        resp_fault = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2
    miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_req && !hit_any |=> walk_req_valid && !req_ready
                                  && walk_req_page == $past(key_page));

    // R4
    fault_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) && walk_rsp_valid && !walk_rsp_present
        |=> r_q.valid == $past(r_q.valid) && r_q.page == $past(r_q.page));

    // R5
    fill_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> r_q.valid[$past(vic)] && r_q.refb[$past(vic)]);

    // R5
    hit_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_req && hit_any |=> r_q.refb[$past(hit_idx)]);

    // R6
    fill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        install && has_free |-> !r_q.valid[vic] && hand_nx == hand_eff);

    // R8
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        install |-> CNT_W'(vic) < act_eff);

    // R3
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: tb/tlb_clock_tb.sv
module tlb_clock_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  active_ways = 4'd3;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        walk_req_valid;
    logic [19:0] walk_req_page;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_present = 1'b0;
    logic [19:0] walk_rsp_frame = '0;

    always #5 clk = ~clk;

    tlb_clock u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .active_ways      (active_ways),
        .req_valid        (req_valid),
        .req_vaddr        (req_vaddr),
        .req_ready        (req_ready),
        .resp_valid       (resp_valid),
        .resp_paddr       (resp_paddr),
        .resp_fault       (resp_fault),
        .walk_req_valid   (walk_req_valid),
        .walk_req_page    (walk_req_page),
        .walk_rsp_valid   (walk_rsp_valid),
        .walk_rsp_present (walk_rsp_present),
        .walk_rsp_frame   (walk_rsp_frame)
    );

    int checks = 0;
    int fails  = 0;
    int faults_seen = 0;
    bit done = 0;

    // behavioural clock model
    bit mv[8];
    bit mr[8];
    int mp[8];
    int mhand = 0;

    function automatic int act_now();
        if (active_ways == 0) return 1;
        if (active_ways > 8) return 8;
        return int'(active_ways);
    endfunction

    function automatic logic [19:0] frame_of(input int page);
        return 20'(page * 3 + 256);
    endfunction

    function automatic bit present_of(input int page);
        return (page % 13) != 12;
    endfunction

    task automatic model_ref(input int page, input bit pres, output bit hit);
        int a = act_now();
        int slot = -1;
        hit = 0;
        for (int i = 0; i < a; i++)
            if (mv[i] && mp[i] == page) begin hit = 1; mr[i] = 1; end
        if (!hit && pres) begin
            for (int i = a - 1; i >= 0; i--) if (!mv[i]) slot = i;
            if (slot < 0) begin
                int h = (mhand >= a) ? 0 : mhand;
                while (mr[h]) begin mr[h] = 0; h = (h + 1) % a; end
                slot  = h;
                mhand = (h + 1) % a;
            end
            mv[slot] = 1; mr[slot] = 1; mp[slot] = page;
        end
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_ref(input int page, input int off);
        bit exp_hit;
        bit pres = present_of(page);
        logic [19:0] fr = frame_of(page);
        logic [11:0] o = 12'(off);
        model_ref(page, pres, exp_hit);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {20'(page), o};
        #2;
        chk(resp_valid == exp_hit, "R1 R6 R7 hit/miss", resp_valid, exp_hit);
        if (exp_hit) begin
            chk(resp_paddr == {fr, o} && !resp_fault, "R1 paddr", resp_paddr, {fr, o});
            @(negedge clk);
            req_valid = 1'b0;
        end else begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(walk_req_valid && walk_req_page == 20'(page), "R2 walk page",
                walk_req_page, page);
            chk(!req_ready && !resp_valid, "R2 busy", req_ready, 0);
            @(negedge clk);
            @(negedge clk);
            walk_rsp_valid   = 1'b1;
            walk_rsp_present = pres;
            walk_rsp_frame   = fr;
            #2;
            chk(resp_valid, "R3 resp", resp_valid, 1);
            chk(resp_fault == !pres, "R4 fault flag", resp_fault, !pres);
            if (pres) chk(resp_paddr == {fr, o}, "R3 paddr", resp_paddr, {fr, o});
            else      chk(resp_paddr == '0, "R4 paddr", resp_paddr, 0);
            if (resp_fault) faults_seen++;
            @(negedge clk);
            walk_rsp_valid = 1'b0;
        end
    endtask

    initial begin
        int stream_a[12] = '{2, 3, 2, 1, 5, 2, 4, 5, 3, 2, 5, 2};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9
        chk(req_ready && !walk_req_valid && !resp_valid, "R9 reset outputs",
            {req_ready, walk_req_valid, resp_valid}, 3'b100);

        // R5 R6 R7: classic stream, three ways
        active_ways = 4'd3;
        for (int i = 0; i < 12; i++) do_ref(stream_a[i], i * 37);

        // R4: absent page misses every time
        do_ref(12, 5);
        do_ref(12, 6);
        chk(faults_seen == 2, "R4 fault count", faults_seen, 2);

        // R7: long sweep with all eight ways
        active_ways = 4'd8;
        for (int i = 0; i < 60; i++) do_ref((i * 5 + i / 3) % 15, i * 91);

        // R8: shrink to three, then one, then zero and oversize
        active_ways = 4'd3;
        for (int i = 0; i < 20; i++) do_ref((i * 7) % 9, i);
        active_ways = 4'd1;
        for (int i = 0; i < 8; i++) do_ref(i % 3, i);
        active_ways = 4'd0;
        for (int i = 0; i < 6; i++) do_ref(i % 2, i);
        active_ways = 4'd15;
        for (int i = 0; i < 30; i++) do_ref((i * 3) % 10, i);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule